// File: doc/BRIEF.md
# Switchable Fast-RAM Overlay Decoder

This block decides, for every processor memory cycle, whether a 64 KB word-wide fast RAM answers or whether the device that normally lives at that address (boot ROM, cartridge space, memory-mapped I/O or a slower external RAM) answers. The 64 KB map is split into eight 8 KB windows selected by the top three address bits. Four of those windows (0x2000, 0xA000, 0xC000, 0xE000) form one 32 KB group that is switched as a unit. The other four windows (0x0000, 0x4000, 0x6000, 0x8000) each have their own switch.

The switches are five single-bit latches that the processor sets and clears over a serial bit-I/O bus, starting at bit address 0x0400. Reset turns the 32 KB group on and all four individual windows off, so the boot ROM is seen again after every restart. A window that is switched off is fully transparent: reads and writes both go to the original device, and nothing is written into the hidden RAM. A window that is switched on takes both reads and writes away from the original device. Whenever the RAM is selected, the external-device inhibit is raised in the same cycle.

Top module: `overlayDecoder`

## Requirements
- R1: After reset, enable bit 0 (the 32 KB group) reads back 1 and enable bits 1 to 4 read back 0.
- R2: A bit-I/O write with `bitIoWr`=1 at address 0x0400+k, for k from 0 to 4, loads `bitIoDin` into enable bit k on the next rising clock edge. Accesses from the following cycle onward see the new value. Bit 0 switches the window set {0x2000, 0xA000, 0xC000, 0xE000}. Bits 1, 2, 3 and 4 switch the windows at 0x0000, 0x4000, 0x6000 and 0x8000 respectively.
- R3: `bitIoDout` shows the current value of enable bit k while `bitIoAddr` is 0x0400+k, and shows 0 for any other bit address.
- R4: During a memory cycle (`memReq`=1) to a window whose enable bit is 1, `ramSel`=1 and `extInhibit`=1 in that same cycle, for both reads and writes.
- R5: During a memory cycle to a window whose enable bit is 0, `ramSel`, `ramWe` and `extInhibit` are all 0, for reads and for writes (no write-through).
- R6: `ramWe` is 1 exactly when `ramSel` is 1 and `writeReq` is 1.
- R7: `ramAddr` equals the word address `cpuAddr[15:1]`.
- R8: While `memReq`=0, `ramSel`, `ramWe` and `extInhibit` stay 0, whatever the enable bits hold.
- R9: Bit-I/O writes to addresses outside 0x0400 to 0x0404 change no enable bit.
- R10: The four windows of the 32 KB group are always all selected or all unselected together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 15 | Processor word address, bits 15 down to 1 |
| memReq | input | 1 | A memory cycle is in progress |
| writeReq | input | 1 | The memory cycle is a write (1) or a read (0) |
| bitIoAddr | input | 16 | Bit-I/O bit address |
| bitIoWr | input | 1 | Bit-I/O write strobe |
| bitIoDin | input | 1 | Bit value to write |
| bitIoDout | output | 1 | Read-back value of the addressed bit |
| ramSel | output | 1 | Fast-RAM chip select |
| ramWe | output | 1 | Fast-RAM write enable |
| ramAddr | output | 15 | Fast-RAM word address |
| extInhibit | output | 1 | Suppresses the select of the original device |

## Verification
A bit-I/O write that changes an enable bit can happen in the same cycle as a memory access to the window that bit controls. The bench drives both in one cycle, with the access to 0x6000 and the write setting bit 3. It expects the access in that cycle to be decoded with the old setting (RAM not selected) and the same access one cycle later to go to the RAM. It then clears the bit the same way and expects the reverse.

// File: rtl/overlayPkg.sv
package overlayPkg;
  localparam int ADDR_W   = 16;
  localparam int SEG_BITS = 3;
  localparam int NUM_SEGS = 1 << SEG_BITS;
  localparam int NUM_EN   = 5;
  localparam int EN_IDX_W = $clog2(NUM_EN);
  localparam logic [NUM_EN-1:0] EN_RESET = 5'b00001;

  typedef struct packed {
    logic [NUM_EN-1:0] segEnable;
  } ctrlStrobes_t;

  // Which enable bit governs each 8 KB window.
  function automatic logic [EN_IDX_W-1:0] enBitForSeg(input logic [SEG_BITS-1:0] seg);
    case (seg)
      3'd0:    return EN_IDX_W'(1);
      3'd2:    return EN_IDX_W'(2);
      3'd3:    return EN_IDX_W'(3);
      3'd4:    return EN_IDX_W'(4);
      default: return EN_IDX_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/overlayCtrl.sv
module overlayCtrl
  import overlayPkg::*;
#(
  parameter logic [15:0] BIT_BASE = 16'h0400
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [15:0]  bitIoAddr,
  input  logic         bitIoWr,
  input  logic         bitIoDin,
  output logic         bitIoDout,
  output ctrlStrobes_t strobes
);
  logic [NUM_EN-1:0] enLatch;
  logic [15:0]       offset;
  logic              inWindow;

  assign offset   = bitIoAddr - BIT_BASE;
  assign inWindow = (offset < 16'(NUM_EN));

  genvar k;
  generate
    for (k = 0; k < NUM_EN; k++) begin : g_latch
      logic hit;
      assign hit = bitIoWr && (bitIoAddr == 16'(BIT_BASE + 16'(k)));
      always_ff @(posedge clk) begin
        if (!rstN)    enLatch[k] <= EN_RESET[k];
        else if (hit) enLatch[k] <= bitIoDin;
      end
    end
  endgenerate

  always_comb begin
    bitIoDout = 1'b0;
    if (inWindow) bitIoDout = enLatch[offset[EN_IDX_W-1:0]];
  end

  assign strobes.segEnable = enLatch;
endmodule

// File: rtl/overlayDatapath.sv
module overlayDatapath
  import overlayPkg::*;
(
  input  logic [ADDR_W-1:1] cpuAddr,
  input  logic              memReq,
  input  logic              writeReq,
  input  ctrlStrobes_t      strobes,
  output logic              ramSel,
  output logic              ramWe,
  output logic [ADDR_W-2:0] ramAddr,
  output logic              extInhibit
);
  logic [SEG_BITS-1:0] segIdx;
  logic [NUM_SEGS-1:0] segOn;

  assign segIdx = cpuAddr[ADDR_W-1 -: SEG_BITS];

  genvar s;
  generate
    for (s = 0; s < NUM_SEGS; s++) begin : g_seg
      assign segOn[s] = strobes.segEnable[enBitForSeg(SEG_BITS'(s))];
    end
  endgenerate

  assign ramSel     = memReq && segOn[segIdx];
  assign ramWe      = ramSel && writeReq;
  assign extInhibit = ramSel;
  assign ramAddr    = cpuAddr;
endmodule

// File: rtl/overlayDecoder.sv
module overlayDecoder
  import overlayPkg::*;
#(
  parameter logic [15:0] BIT_BASE = 16'h0400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:1] cpuAddr,
  input  logic        memReq,
  input  logic        writeReq,
  input  logic [15:0] bitIoAddr,
  input  logic        bitIoWr,
  input  logic        bitIoDin,
  output logic        bitIoDout,
  output logic        ramSel,
  output logic        ramWe,
  output logic [14:0] ramAddr,
  output logic        extInhibit
);
  ctrlStrobes_t strobes;

  overlayCtrl #(.BIT_BASE(BIT_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitIoAddr(bitIoAddr), .bitIoWr(bitIoWr),
    .bitIoDin(bitIoDin), .bitIoDout(bitIoDout), .strobes(strobes)
  );

  overlayDatapath u_dp (
    .cpuAddr(cpuAddr), .memReq(memReq), .writeReq(writeReq), .strobes(strobes),
    .ramSel(ramSel), .ramWe(ramWe), .ramAddr(ramAddr), .extInhibit(extInhibit)
  );
endmodule

// File: rtl/overlayDecoder_check.sv
module overlayDecoder_check #(
  parameter logic [15:0] BIT_BASE = 16'h0400
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:1] cpuAddr,
  input logic        memReq,
  input logic        writeReq,
  input logic [15:0] bitIoAddr,
  input logic        bitIoWr,
  input logic        bitIoDin,
  input logic        bitIoDout,
  input logic        ramSel,
  input logic        ramWe,
  input logic [14:0] ramAddr,
  input logic        extInhibit
);
  logic inWin;
  assign inWin = (bitIoAddr >= BIT_BASE) && (bitIoAddr < BIT_BASE + 16'd5);

  assert_we_needs_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (writeReq && memReq));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> (!ramSel && !ramWe && !extInhibit));

  assert_inhibit_in_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    extInhibit |-> memReq);

  assert_group_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bitIoWr && bitIoAddr == BIT_BASE && bitIoDin) |=>
      (!(memReq && cpuAddr[15:13] == 3'd5) || ramSel));

  assert_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bitIoWr && inWin) |=>
      (bitIoAddr != $past(bitIoAddr) || bitIoDout == $past(bitIoDin)));
endmodule

bind overlayDecoder overlayDecoder_check #(.BIT_BASE(BIT_BASE)) u_chk (.*);

// File: tb/overlayDecoder_bench.sv
module overlayDecoder_bench;
  localparam logic [15:0] BASE = 16'h0400;

  logic        clk = 0;
  logic        rstN = 0;
  logic [15:1] cpuAddr = '0;
  logic        memReq = 0, writeReq = 0;
  logic [15:0] bitIoAddr = '0;
  logic        bitIoWr = 0, bitIoDin = 0;
  logic        bitIoDout, ramSel, ramWe, extInhibit;
  logic [14:0] ramAddr;

  int errors = 0;
  int checks = 0;
  logic [4:0] model;
  bit finished = 0;

  always #5 clk = ~clk;

  overlayDecoder u_overlayDecoder (.*);

  function automatic int enBitOf(input logic [2:0] seg);
    case (seg)
      3'd0: return 1;
      3'd2: return 2;
      3'd3: return 3;
      3'd4: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitWrite(input logic [15:0] a, input logic v);
    @(negedge clk);
    bitIoAddr = a; bitIoDin = v; bitIoWr = 1;
    @(negedge clk);
    bitIoWr = 0;
    if (a >= BASE && a < BASE + 16'd5) model[a - BASE] = v;
  endtask

  task automatic doReset;
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
    model = 5'b00001;
  endtask

  // One access; compare outputs against the model
  task automatic access(input logic [15:0] a, input logic wr, input string tag);
    logic exp;
    @(negedge clk);
    cpuAddr = a[15:1]; memReq = 1; writeReq = wr;
    #2;
    exp = model[enBitOf(a[15:13])];
    chk({tag, exp ? " R4 sel" : " R5 sel"}, ramSel, exp);
    chk({tag, exp ? " R4 inh" : " R5 inh"}, extInhibit, exp);
    chk({tag, " R6 we"}, ramWe, exp & wr);
    chk({tag, " R7 addr"}, ramAddr, a[15:1]);
    memReq = 0; writeReq = 0;
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 8; s++) begin
      access(16'(s << 13) | 16'h0124, 1'b0, tag);
      access(16'(s << 13) | 16'h1FFE, 1'b1, tag);
    end
  endtask

  task automatic readAll(input string tag);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      bitIoAddr = BASE + 16'(k); #1;
      chk({tag, " R3 readback"}, bitIoDout, model[k]);
    end
  endtask

  task automatic t_reset;
    doReset();
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      bitIoAddr = BASE + 16'(k); #1;
      chk("R1 reset bit", bitIoDout, (k == 0));
    end
    sweep("R1 default map");
  endtask

  task automatic t_individual;
    for (int k = 1; k < 5; k++) begin
      bitWrite(BASE + 16'(k), 1'b1);
      readAll("R2 set");
      sweep("R2 one window");
    end
    bitWrite(BASE, 1'b0);
    sweep("R10 group off");
    bitWrite(BASE + 16'd2, 1'b0);
    bitWrite(BASE + 16'd4, 1'b0);
    sweep("R2 cleared");
    bitWrite(BASE, 1'b1);
    sweep("R10 group on");
  endtask

  task automatic t_sameCycle;
    @(negedge clk);
    bitIoAddr = BASE + 16'd3; bitIoDin = 0; bitIoWr = 1;
    @(negedge clk); bitIoWr = 0; model[3] = 0;
    @(negedge clk);
    bitIoAddr = BASE + 16'd3; bitIoDin = 1; bitIoWr = 1;
    cpuAddr = 16'h6000 >> 1; memReq = 1; writeReq = 1;
    #2;
    chk("R2 same-cycle old", ramSel, 1'b0);
    chk("R5 same-cycle no write", ramWe, 1'b0);
    @(negedge clk); bitIoWr = 0; model[3] = 1; #2;
    chk("R2 next-cycle new", ramSel, 1'b1);
    chk("R4 next-cycle inh", extInhibit, 1'b1);
    bitIoDin = 0; bitIoWr = 1;
    @(negedge clk); bitIoWr = 0; model[3] = 0; #2;
    chk("R2 cleared next cycle", ramSel, 1'b0);
    memReq = 0; writeReq = 0;
  endtask

  task automatic t_outOfRange;
    bitWrite(BASE + 16'd5, 1'b1);
    bitWrite(BASE - 16'd1, 1'b1);
    bitWrite(16'h0000, 1'b1);
    bitWrite(BASE + 16'h0100, 1'b1);
    readAll("R9 unchanged");
    sweep("R9 map unchanged");
    @(negedge clk);
    bitIoAddr = BASE + 16'd5; #1;
    chk("R3 out-of-window read", bitIoDout, 1'b0);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 5; k++) bitWrite(BASE + 16'(k), 1'b1);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      cpuAddr = 15'(s << 12); memReq = 0; writeReq = 1; #2;
      chk("R8 idle sel", ramSel, 1'b0);
      chk("R8 idle we", ramWe, 1'b0);
      chk("R8 idle inh", extInhibit, 1'b0);
    end
    writeReq = 0;
    sweep("R4 all on");
  endtask

  task automatic t_reReset;
    doReset();
    readAll("R1 re-reset");
    sweep("R1 re-reset map");
  endtask

  initial begin
    model = 5'b00001;
    t_reset();
    t_individual();
    t_sameCycle();
    t_outOfRange();
    t_idle();
    t_reReset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule